// File: doc/BRIEF.md
# Set-Associative Write-Through Cache

This block is a parameterised set-associative cache placed between a processor request port and a memory port. Loads that find their line are answered from internal storage in the cycle the request is presented. Loads that miss fetch the whole line from memory, one word per accepted memory beat, and then answer the processor. Stores always go to memory. If the addressed line is resident, its cached word is also patched under the byte mask. A store that misses allocates nothing.

When a load miss needs a line slot, the cache takes the lowest-numbered empty way of the indexed set. If the set is full, it takes the way named by one rotating pointer that serves every set. Two event counters record hits and misses. A statistics-enable input stops both counters while a program image is being copied into memory. A synchronous flush empties the cache and clears the pointer and both counters.

The same module is instantiated once for instructions and once for data, each instance with its own geometry. `LINE_BYTES` must be a whole multiple of the word size in bytes. `NUM_WAYS` and `NUM_SETS` must be at least one, and sets and words per line must be powers of two.

Top module: `wt_cache`

## Requirements
- R1: A load that hits raises `cpu_ready_o` in the same cycle as `cpu_req_i` with the stored word on `cpu_rdata_o`, and makes no memory request.
- R2: A load miss reads the whole line, word by word, starting at the line base address and going up in word steps. `cpu_ready_o` rises on the last accepted beat, carrying the requested word; with no memory stalls this is 4 cycles after the request is accepted for a 4-word line.
- R3: Every store, hit or miss, issues one memory write with the processor's address, data and byte mask. `cpu_ready_o` rises in the cycle memory accepts it, which is one cycle after acceptance with no stalls.
- R4: A store hit updates the cached word only in bytes whose `cpu_be_i` bit is 1 (bit n covers data bits 8n+7..8n). A store miss leaves the cache unchanged, so a following load of that line misses.
- R5: A load miss fills the lowest-numbered invalid way of the indexed set, and this does not move the replacement pointer.
- R6: When all ways of the set are valid, the victim is the way named by a single pointer shared by all sets. The pointer steps by one modulo `NUM_WAYS` only when a valid line is replaced.
- R7: Each accepted access adds exactly one to `hit_count_o` (line resident, load or store) or to `miss_count_o`.
- R8: While `stat_en_i` is 0, accesses are served normally and neither counter changes.
- R9: A cycle with `flush_i` high invalidates every line, returns the pointer to way 0 and clears both counters.
- R10: After reset, all lines are invalid, both counters read 0 and `cpu_ready_o` and `mem_req_o` are low.
- R11: While `mem_ready_i` is low, the pending memory request holds its address and direction, and no fill beat or processor reply is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous invalidate-all, pointer and counter clear |
| stat_en_i | input | 1 | Enables the hit and miss counters |
| cpu_req_i | input | 1 | Processor request, held until `cpu_ready_o` |
| cpu_we_i | input | 1 | 1 for store, 0 for load |
| cpu_addr_i | input | ADDR_W | Byte address, word aligned |
| cpu_wdata_i | input | WORD_W | Store data |
| cpu_be_i | input | WORD_W/8 | Store byte mask |
| cpu_ready_o | output | 1 | Access completes at this clock edge |
| cpu_rdata_o | output | WORD_W | Load data, valid with `cpu_ready_o` |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | WORD_W | Memory write data |
| mem_be_o | output | WORD_W/8 | Memory write byte mask |
| mem_ready_i | input | 1 | Memory accepts the beat; read data valid this cycle |
| mem_rdata_i | input | WORD_W | Memory read data |
| hit_count_o | output | CNT_W | Hit count |
| miss_count_o | output | CNT_W | Miss count |

## Verification
A stale or wrongly merged data word shows up on the very next load hit to that address, as a `cpu_rdata_o` value that differs from memory. A corrupt valid bit, tag or replacement pointer cannot be seen directly. It shows up at the next access to an affected line: a hit that should be a miss, or the reverse. At the ports this appears in the same access as a reply latency of 0 instead of 4 cycles (or the reverse) and as a counter pair that disagrees with an arithmetic model of the lowest-invalid-then-shared-pointer policy. Fill ordering and store forwarding errors show on the memory port within the same access.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_WRITE
  } cache_state_e;
endpackage

// File: rtl/wt_cache_tags.sv
module wt_cache_tags #(
  parameter int unsigned NUM_WAYS = 2,
  parameter int unsigned NUM_SETS = 4,
  parameter int unsigned TAG_W    = 26,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned WAY_W    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] look_idx_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAY_W-1:0] victim_o,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic [TAG_W-1:0] fill_tag_i
);
  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0]    rr_q;
  logic [NUM_WAYS-1:0] match;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[look_idx_i][w] && (tag_q[look_idx_i][w] == look_tag_i);
  end

  always_comb begin
    hit_o     = |match;
    hit_way_o = '0;
    victim_o  = rr_q;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way_o = WAY_W'(w);
      if (!valid_q[look_idx_i][w]) victim_o = WAY_W'(w);  // lowest empty way wins
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
      for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
    end else if (flush_i) begin
      rr_q <= '0;
      for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
    end else if (fill_i) begin
      if (valid_q[fill_idx_i][fill_way_i])
        rr_q <= (rr_q == WAY_W'(NUM_WAYS - 1)) ? '0 : rr_q + WAY_W'(1);
      valid_q[fill_idx_i][fill_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[fill_idx_i][fill_way_i] <= fill_tag_i;
  end
endmodule

// File: rtl/wt_cache_data.sv
module wt_cache_data #(
  parameter int unsigned NUM_SETS = 4,
  parameter int unsigned NUM_WAYS = 2,
  parameter int unsigned WORDS    = 4,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned WAY_W    = 1,
  parameter int unsigned WOFF_W   = 2,
  localparam int unsigned BE_W    = WORD_W / 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [WOFF_W-1:0] wr_word_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [WOFF_W-1:0] rd_word_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [NUM_SETS][NUM_WAYS][WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be_i[b]) mem_q[wr_idx_i][wr_way_i][wr_word_i][b*8 +: 8] <= wr_data_i[b*8 +: 8];
      end
    end
  end

  assign rd_data_o = mem_q[rd_idx_i][rd_way_i][rd_word_i];
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wt_cache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned NUM_WAYS   = 2,
  parameter int unsigned NUM_SETS   = 4,
  parameter int unsigned CNT_W      = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                stat_en_i,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic [WORD_W-1:0]   cpu_wdata_i,
  input  logic [WORD_W/8-1:0] cpu_be_i,
  output logic                cpu_ready_o,
  output logic [WORD_W-1:0]   cpu_rdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  output logic [WORD_W/8-1:0] mem_be_o,
  input  logic                mem_ready_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic [CNT_W-1:0]    hit_count_o,
  output logic [CNT_W-1:0]    miss_count_o
);
  localparam int unsigned BE_W      = WORD_W / 8;
  localparam int unsigned WORDS     = LINE_BYTES / BE_W;
  localparam int unsigned BYTE_BITS = $clog2(BE_W);
  localparam int unsigned OFF_BITS  = $clog2(LINE_BYTES);
  localparam int unsigned IDX_BITS  = $clog2(NUM_SETS);
  localparam int unsigned IDX_W     = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int unsigned WOFF_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int unsigned TAG_W     = ADDR_W - OFF_BITS - IDX_BITS;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    if (IDX_BITS == 0) return '0;
    return IDX_W'(a >> OFF_BITS);
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> (OFF_BITS + IDX_BITS));
  endfunction

  function automatic logic [WOFF_W-1:0] woff_of(input logic [ADDR_W-1:0] a);
    if (WORDS == 1) return '0;
    return WOFF_W'(a >> BYTE_BITS);
  endfunction

  cache_state_e      st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, crit_q;
  logic [BE_W-1:0]   be_q;
  logic [WOFF_W-1:0] beat_q;
  logic [WAY_W-1:0]  vict_q;
  logic [CNT_W-1:0]  hit_cnt_q, miss_cnt_q;

  logic              hit, accept, st_hit, fill_beat, last_beat;
  logic [WAY_W-1:0]  hit_way, vict_way;
  logic [WORD_W-1:0] rd_word;

  assign accept    = (st_q == ST_IDLE) && cpu_req_i && !flush_i;
  assign st_hit    = accept && cpu_we_i && hit;
  assign fill_beat = (st_q == ST_FILL) && mem_ready_i;
  assign last_beat = (beat_q == WOFF_W'(WORDS - 1));

  wt_cache_tags #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .look_idx_i (idx_of(cpu_addr_i)),
    .look_tag_i (tag_of(cpu_addr_i)),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .victim_o   (vict_way),
    .fill_i     (fill_beat && last_beat),
    .fill_idx_i (idx_of(addr_q)),
    .fill_way_i (vict_q),
    .fill_tag_i (tag_of(addr_q))
  );

  wt_cache_data #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .WORDS(WORDS), .WORD_W(WORD_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W), .WOFF_W(WOFF_W)
  ) u_data (
    .clk_i     (clk_i),
    .we_i      (st_hit || fill_beat),
    .wr_idx_i  (fill_beat ? idx_of(addr_q) : idx_of(cpu_addr_i)),
    .wr_way_i  (fill_beat ? vict_q : hit_way),
    .wr_word_i (fill_beat ? beat_q : woff_of(cpu_addr_i)),
    .wr_data_i (fill_beat ? mem_rdata_i : cpu_wdata_i),
    .wr_be_i   (fill_beat ? {BE_W{1'b1}} : cpu_be_i),
    .rd_idx_i  (idx_of(cpu_addr_i)),
    .rd_way_i  (hit_way),
    .rd_word_i (woff_of(cpu_addr_i)),
    .rd_data_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      beat_q     <= '0;
      vict_q     <= '0;
      crit_q     <= '0;
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
    end else if (flush_i) begin
      st_q       <= ST_IDLE;
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q  <= cpu_addr_i;
          wdata_q <= cpu_wdata_i;
          be_q    <= cpu_be_i;
          beat_q  <= '0;
          vict_q  <= vict_way;
          if (cpu_we_i) st_q <= ST_WRITE;
          else if (!hit) st_q <= ST_FILL;
          if (stat_en_i) begin
            if (hit) hit_cnt_q <= hit_cnt_q + CNT_W'(1);
            else     miss_cnt_q <= miss_cnt_q + CNT_W'(1);
          end
        end
        ST_FILL: if (mem_ready_i) begin
          beat_q <= beat_q + WOFF_W'(1);
          if (beat_q == woff_of(addr_q)) crit_q <= mem_rdata_i;
          if (last_beat) st_q <= ST_IDLE;
        end
        ST_WRITE: if (mem_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cpu_ready_o = 1'b0;
    unique case (st_q)
      ST_IDLE:  cpu_ready_o = accept && !cpu_we_i && hit;
      ST_FILL:  cpu_ready_o = mem_ready_i && last_beat;
      ST_WRITE: cpu_ready_o = mem_ready_i;
      default:  cpu_ready_o = 1'b0;
    endcase
  end

  // Critical word may arrive on the completing beat itself.
  assign cpu_rdata_o  = (st_q != ST_FILL) ? rd_word :
                        (beat_q == woff_of(addr_q)) ? mem_rdata_i : crit_q;
  assign mem_req_o    = (st_q != ST_IDLE);
  assign mem_we_o     = (st_q == ST_WRITE);
  assign mem_addr_o   = (st_q == ST_WRITE) ? addr_q :
                        ((addr_q & ~ADDR_W'(LINE_BYTES - 1)) | (ADDR_W'(beat_q) << BYTE_BITS));
  assign mem_wdata_o  = wdata_q;
  assign mem_be_o     = (st_q == ST_WRITE) ? be_q : {BE_W{1'b1}};
  assign hit_count_o  = hit_cnt_q;
  assign miss_count_o = miss_cnt_q;
endmodule

// File: rtl/wt_cache_checker.sv
module wt_cache_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              stat_en_i,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic              cpu_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [CNT_W-1:0]  hit_count_o,
  input logic [CNT_W-1:0]  miss_count_o
);
  a_r1_no_reply_unasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> !cpu_ready_o);

  a_r1_local_reply_is_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && !mem_req_o |-> !cpu_we_i);

  a_r3_store_via_memory: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && cpu_we_i |-> mem_req_o && mem_we_o && mem_ready_i);

  a_r11_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i && !flush_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r11_reply_needs_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && mem_req_o |-> mem_ready_i);

  a_r7_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> ((hit_count_o - $past(hit_count_o)) + (miss_count_o - $past(miss_count_o))) <= CNT_W'(1));

  a_r8_gated_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_en_i && !flush_i |=> $stable(hit_count_o) && $stable(miss_count_o));

  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (hit_count_o == '0) && (miss_count_o == '0) && !mem_req_o);
endmodule

bind wt_cache wt_cache_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .stat_en_i    (stat_en_i),
  .cpu_req_i    (cpu_req_i),
  .cpu_we_i     (cpu_we_i),
  .cpu_ready_o  (cpu_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_ready_i  (mem_ready_i),
  .mem_addr_o   (mem_addr_o),
  .hit_count_o  (hit_count_o),
  .miss_count_o (miss_count_o)
);

// File: tb/wt_cache_tb_top.sv
`timescale 1ns/1ps
module wt_cache_tb_top;
  localparam int WAYS = 2;
  localparam int SETS = 4;
  localparam int LB   = 16;
  localparam int WRDS = LB / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, stat_en = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [31:0] hit_cnt, miss_cnt;

  logic        stall_en = 1'b0;
  logic [7:0]  stall_lfsr = 8'h5b;
  logic [31:0] mem_m [256];
  int          beat_k, mon_checks, mon_errs;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wt_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .stat_en_i(stat_en),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_be_i(cpu_be), .cpu_ready_o(cpu_ready),
    .cpu_rdata_o(cpu_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .hit_count_o(hit_cnt), .miss_count_o(miss_cnt)
  );

  assign mem_ready = mem_req && (!stall_en || stall_lfsr[0]);
  assign mem_rdata = mem_m[mem_addr[9:2]];

  always @(negedge clk) stall_lfsr <= {stall_lfsr[6:0], stall_lfsr[7] ^ stall_lfsr[5] ^ stall_lfsr[4] ^ stall_lfsr[3]};

  // Memory model and memory-port monitor (R2 fill order, R3 store forwarding)
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_m[i] <= (i * 32'h9e3779b9) ^ 32'h00c0ffee;
      beat_k <= 0; mon_checks <= 0; mon_errs <= 0;
    end else if (!mem_req) begin
      beat_k <= 0;
    end else if (mem_ready) begin
      mon_checks <= mon_checks + 1;
      if (mem_we) begin
        if (mem_addr != cpu_addr || mem_wdata != cpu_wdata || mem_be != cpu_be) begin
          mon_errs <= mon_errs + 1;
          $display("FAIL R3 store forward actual=%h/%h/%h expected=%h/%h/%h",
                   mem_addr, mem_wdata, mem_be, cpu_addr, cpu_wdata, cpu_be);
        end
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem_m[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        if (mem_addr != ((cpu_addr & ~32'(LB - 1)) + 32'(4 * beat_k))) begin
          mon_errs <= mon_errs + 1;
          $display("FAIL R2 fill address actual=%h expected=%h", mem_addr,
                   (cpu_addr & ~32'(LB - 1)) + 32'(4 * beat_k));
        end
        beat_k <= beat_k + 1;
      end
    end
  end

  // Reference cache state
  bit m_valid [SETS][WAYS];
  int m_tag   [SETS][WAYS];
  int m_rr, m_hits, m_miss;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) m_valid[s][w] = 1'b0;
    m_rr = 0; m_hits = 0; m_miss = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    model_clear();
    chk(hit_cnt == 0 && miss_cnt == 0, "R9", "counters after flush", hit_cnt | miss_cnt, 0);
  endtask

  task automatic do_access(input bit we, input logic [9:0] a, input logic [31:0] d,
                           input logic [3:0] be, input string rq);
    int set = (a >> 4) % SETS;
    int tag = a >> 6;
    int hw = -1;
    int cyc = 0;
    int exp_lat;
    logic [31:0] exp_d, got;
    for (int w = 0; w < WAYS; w++) if (m_valid[set][w] && m_tag[set][w] == tag) hw = w;
    exp_d = mem_m[a[9:2]];
    if (stat_en) begin
      if (hw >= 0) m_hits++; else m_miss++;
    end
    if (!we && hw < 0) begin
      int v = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[set][w]) v = w;
      if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % WAYS; end
      m_valid[set][v] = 1'b1; m_tag[set][v] = tag;
    end
    exp_lat = we ? 1 : ((hw >= 0) ? 0 : WRDS);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = {22'b0, a}; cpu_wdata = d; cpu_be = be;
    got = '0;
    forever begin
      #1;
      if (cpu_ready) begin got = cpu_rdata; break; end
      if (cyc > 200) break;
      @(negedge clk); cyc++;
    end
    @(posedge clk); #1 cpu_req = 1'b0;
    if (!we) chk(got == exp_d, rq, "load data", got, exp_d);
    if (!stall_en) chk(cyc == exp_lat, rq, "reply latency", cyc, exp_lat);
    else chk(cyc >= exp_lat && cyc <= 200, "R11", "stalled latency", cyc, exp_lat);
    chk(hit_cnt == m_hits, stat_en ? "R7" : "R8", "hit count", hit_cnt, m_hits);
    chk(miss_cnt == m_miss, stat_en ? "R7" : "R8", "miss count", miss_cnt, m_miss);
  endtask

  task automatic sweep(input int n, inout logic [15:0] lf);
    for (int i = 0; i < n; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_access(lf[3:0] < 4'd5, {1'b0, lf[12:6], 2'b00}, {lf, ~lf}, lf[15:12],
                lf[3:0] < 4'd5 ? "R3" : "R1");
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors + mon_errs + 1, checks + mon_checks + 1);
    $finish;
  end

  initial begin : main
    logic [15:0] lf = 16'hace1;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    chk(!cpu_ready && !mem_req, "R10", "ready/req in reset", {cpu_ready, mem_req}, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(hit_cnt == 0 && miss_cnt == 0, "R10", "counters after reset", hit_cnt | miss_cnt, 0);
    do_access(1'b0, 10'h000, 0, 0, "R10");  // all invalid: must miss

    // Load phase with counters held off (R8)
    sweep(24, lf);
    chk(hit_cnt == 0 && miss_cnt == 0, "R8", "gated counters", hit_cnt | miss_cnt, 0);

    stat_en = 1'b1;
    do_flush();
    do_access(1'b0, 10'h000, 0, 0, "R9");   // flushed line misses

    // Victim choice: set 0 ways, then shared pointer (R5, R6)
    do_access(1'b0, 10'h040, 0, 0, "R5");   // set0 way1 empty
    do_access(1'b0, 10'h010, 0, 0, "R5");   // set1 way0
    do_access(1'b0, 10'h080, 0, 0, "R6");   // set0 full, ptr 0 -> evict tag0
    do_access(1'b0, 10'h040, 0, 0, "R6");   // still resident, hit
    do_access(1'b0, 10'h000, 0, 0, "R6");   // ptr 1 -> evict tag1
    do_access(1'b0, 10'h040, 0, 0, "R6");   // miss, ptr 0 evicts tag2
    do_access(1'b0, 10'h050, 0, 0, "R5");   // set1 way1 empty, ptr unchanged
    do_access(1'b0, 10'h090, 0, 0, "R6");   // set1 full, shared ptr 1 -> evict 0x050
    do_access(1'b0, 10'h010, 0, 0, "R6");   // hit

    // Store hit merge and store miss no-allocate (R4)
    do_access(1'b1, 10'h014, 32'h11223344, 4'b0101, "R4");
    do_access(1'b0, 10'h014, 0, 0, "R4");   // hit with merged bytes
    do_access(1'b1, 10'h1c4, 32'hdeadbeef, 4'b1111, "R4");
    do_access(1'b0, 10'h1c4, 0, 0, "R4");   // must miss

    // Flush resets the shared pointer (R9)
    do_access(1'b0, 10'h100, 0, 0, "R6");
    do_access(1'b0, 10'h140, 0, 0, "R6");
    do_flush();
    do_access(1'b0, 10'h000, 0, 0, "R9");
    do_access(1'b0, 10'h040, 0, 0, "R9");
    do_access(1'b0, 10'h080, 0, 0, "R9");   // ptr 0 -> evict 0x000
    do_access(1'b0, 10'h040, 0, 0, "R9");   // hit
    do_access(1'b0, 10'h000, 0, 0, "R9");   // miss

    sweep(300, lf);
    stall_en = 1'b1;
    sweep(300, lf);
    stall_en = 1'b0;
    sweep(50, lf);

    repeat (2) @(posedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors + mon_errs, checks + mon_checks);
    $finish;
  end
endmodule